// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block holds a small array of words in an internal register memory and rearranges them into ascending order. The host fills the array while the mode pin `start_i` is low, raises `start_i` to launch the sort, waits for `done_o`, drops `start_i`, and then reads the words back. All memory traffic, from the host or from the sorter, goes through one address port. Each compare-and-exchange therefore runs as a fixed series of single-port cycles.

The sort is an exchange (selection-style) sort. An outer index walks positions 0 to DEPTH-2 and holds the current word of that position in register A. An inner index walks every later position and loads each word into register B. Whenever A is strictly greater than B, the two words are exchanged in memory and A is refreshed from memory. Because reads have one cycle of latency, every address change is followed by a wait cycle before a register load. Terminal flags on the two indices end the loops.

Data leaves the block through a valid-only read stream. A read request produces one `out_valid_o` pulse one cycle later. There is no ready input, so the host must capture the word in the cycle it is valid. Writes are single-cycle strobes with no back-pressure, and they are accepted only in load mode.

Top module: `exch_sorter`

## Requirements
- R1: `rst_ni` is an active-low asynchronous reset. It may be applied at any time, including in the middle of a sort. After it, `done_o` and `out_valid_o` are low and the block is in load mode, ready for a new load-and-sort cycle.
- R2: In load mode (`start_i` low, `done_o` low), a high `wr_i` stores `wdata_i` at address `addr_i` on that clock edge.
- R3: In load mode, a high `rd_i` makes `out_valid_o` high in the next cycle, with `rdata_o` equal to the word at the `addr_i` sampled with the request. While `out_valid_o` is low, `rdata_o` is zero.
- R4: After `start_i` rises in load mode, the array is rearranged so that the word at every address a is less than or equal to the word at address a+1. During each exchange, the smaller word is written to the lower address in one cycle and the larger word to the higher address in the next cycle.
- R5: `done_o` rises when the sort completes and stays high for as long as `start_i` stays high. In the cycle after `start_i` is seen low, `done_o` is low and the block is back in load mode.
- R6: While `start_i` is high, both during the sort and while `done_o` is high, `wr_i` has no effect on the array.
- R7: The sorted array is a permutation of the loaded words, with duplicates kept. Words that compare equal are never exchanged.
- R8: While `start_i` is high, `rd_i` produces no `out_valid_o` pulse.
- R9: `done_o` rises no more than 7*DEPTH*DEPTH cycles after `start_i` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Mode: 0 = load/readout, 1 = sort |
| wr_i | input | 1 | Host write strobe (load mode only) |
| addr_i | input | $clog2(DEPTH) | Host word address |
| wdata_i | input | WIDTH | Host write word |
| rd_i | input | 1 | Host read request (load mode only) |
| out_valid_o | output | 1 | Read word valid, one cycle after request |
| rdata_o | output | WIDTH | Read word, zero when not valid |
| done_o | output | 1 | Sort complete, held while start_i is high |

## Verification
The bench builds the sorter with DEPTH = 5 and WIDTH = 4. The odd depth gives a non-power-of-two address range, with unused address codes and a terminal flag that is not all ones. The 4-bit words make duplicates, all-equal arrays, and the extreme values 0 and 15 easy to load. The patterns cover reversed, shuffled, pre-sorted, all-equal and alternating-extreme arrays. Each sorted readout is checked against a model ordering through a scoreboard. Writes and reads are injected during the sort and during the done phase, and a reset is applied mid-sort.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // load/readout mode
    ST_RDI,    // address = i, wait for read
    ST_LDA,    // A <= M[i], j <= i+1
    ST_RDJ,    // address = j, wait for read
    ST_LDB,    // B <= M[j]
    ST_CMP,    // compare; on A>B write B into M[i]
    ST_WRJ,    // write old A into M[j]
    ST_RDI2,   // address = i after exchange
    ST_LDA2,   // A <= new M[i]
    ST_NEXT,   // advance j or i, or finish
    ST_DONE    // hold done until start drops
  } sort_state_e;

endpackage

// File: rtl/sorter_mem.sv
module sorter_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [DEPTH-1:0][WIDTH-1:0] words;
  logic [WIDTH-1:0]            rdata_q;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [WIDTH-1:0] word_q;
    always_ff @(posedge clk_i) begin
      if (we_i && (addr_i == AW'(w))) word_q <= wdata_i;
    end
    assign words[w] = word_q;
  end

  // registered read: one cycle of latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rdata_q <= '0;
    else if (int'(addr_i) < DEPTH)  rdata_q <= words[addr_i];
    else                            rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/sorter_datapath.sv
module sorter_datapath #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] rdata_i,
  input  logic             ld_i_i,
  input  logic             inc_i_i,
  input  logic             ld_j_i,
  input  logic             inc_j_i,
  input  logic             en_a_i,
  input  logic             en_b_i,
  input  logic             sel_j_i,
  input  logic             wsel_b_i,
  output logic [AW-1:0]    addr_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic             a_gt_b_o,
  output logic             last_i_o,
  output logic             last_j_o
);

  localparam logic [AW-1:0] LAST_I = AW'(DEPTH - 2);
  localparam logic [AW-1:0] LAST_J = AW'(DEPTH - 1);

  logic [AW-1:0]    idx_i_q, idx_j_q;
  logic [WIDTH-1:0] reg_a_q, reg_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_i_q <= '0;
      idx_j_q <= '0;
    end else begin
      if (ld_i_i)       idx_i_q <= '0;
      else if (inc_i_i) idx_i_q <= idx_i_q + 1'b1;
      if (ld_j_i)       idx_j_q <= idx_i_q + 1'b1;
      else if (inc_j_i) idx_j_q <= idx_j_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_q <= '0;
      reg_b_q <= '0;
    end else begin
      if (en_a_i) reg_a_q <= rdata_i;
      if (en_b_i) reg_b_q <= rdata_i;
    end
  end

  assign a_gt_b_o = reg_a_q > reg_b_q;
  assign last_i_o = idx_i_q == LAST_I;
  assign last_j_o = idx_j_q == LAST_J;
  assign addr_o   = sel_j_i ? idx_j_q : idx_i_q;
  assign wdata_o  = wsel_b_i ? reg_b_q : reg_a_q;

  assert_loop_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx_i_q) <= DEPTH - 2) && (int'(idx_j_q) <= DEPTH - 1));

endmodule

// File: rtl/sorter_ctrl.sv
module sorter_ctrl
  import sorter_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic a_gt_b_i,
  input  logic last_i_i,
  input  logic last_j_i,
  output logic ld_i_o,
  output logic inc_i_o,
  output logic ld_j_o,
  output logic inc_j_o,
  output logic en_a_o,
  output logic en_b_o,
  output logic sel_j_o,
  output logic wsel_b_o,
  output logic sort_we_o,
  output logic host_mode_o,
  output logic done_o
);

  sort_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d   = state_q;
    ld_i_o    = 1'b0;
    inc_i_o   = 1'b0;
    ld_j_o    = 1'b0;
    inc_j_o   = 1'b0;
    en_a_o    = 1'b0;
    en_b_o    = 1'b0;
    sel_j_o   = 1'b0;
    wsel_b_o  = 1'b0;
    sort_we_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ld_i_o  = 1'b1;
        state_d = ST_RDI;
      end
      ST_RDI:  state_d = ST_LDA;
      ST_LDA: begin
        en_a_o  = 1'b1;
        ld_j_o  = 1'b1;
        state_d = ST_RDJ;
      end
      ST_RDJ: begin
        sel_j_o = 1'b1;
        state_d = ST_LDB;
      end
      ST_LDB: begin
        en_b_o  = 1'b1;
        state_d = ST_CMP;
      end
      ST_CMP: begin
        if (a_gt_b_i) begin
          sort_we_o = 1'b1;
          wsel_b_o  = 1'b1;
          state_d   = ST_WRJ;
        end else begin
          state_d   = ST_NEXT;
        end
      end
      ST_WRJ: begin
        sort_we_o = 1'b1;
        sel_j_o   = 1'b1;
        state_d   = ST_RDI2;
      end
      ST_RDI2: state_d = ST_LDA2;
      ST_LDA2: begin
        en_a_o  = 1'b1;
        state_d = ST_NEXT;
      end
      ST_NEXT: begin
        if (!last_j_i) begin
          inc_j_o = 1'b1;
          state_d = ST_RDJ;
        end else if (!last_i_i) begin
          inc_i_o = 1'b1;
          state_d = ST_RDI;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: if (!start_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign host_mode_o = state_q == ST_IDLE;
  assign done_o      = state_q == ST_DONE;

  assert_swap_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sort_we_o && wsel_b_o) |=> (sort_we_o && !wsel_b_o));

  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> done_o);

  assert_done_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (!done_o && host_mode_o));

endmodule

// File: rtl/exch_sorter.sv
module exch_sorter #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic             out_valid_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic             done_o
);

  logic             ld_i, inc_i, ld_j, inc_j, en_a, en_b, sel_j, wsel_b;
  logic             sort_we, host_mode, a_gt_b, last_i, last_j;
  logic [AW-1:0]    sort_addr, mem_addr;
  logic [WIDTH-1:0] sort_wdata, mem_wdata, mem_rdata;
  logic             mem_we, host_ok, rd_valid_q;

  // host access only in load mode with start low
  assign host_ok   = host_mode && !start_i;
  assign mem_we    = host_mode ? (wr_i && host_ok) : sort_we;
  assign mem_addr  = host_mode ? addr_i : sort_addr;
  assign mem_wdata = host_mode ? wdata_i : sort_wdata;

  sorter_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  sorter_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rdata_i  (mem_rdata),
    .ld_i_i   (ld_i),
    .inc_i_i  (inc_i),
    .ld_j_i   (ld_j),
    .inc_j_i  (inc_j),
    .en_a_i   (en_a),
    .en_b_i   (en_b),
    .sel_j_i  (sel_j),
    .wsel_b_i (wsel_b),
    .addr_o   (sort_addr),
    .wdata_o  (sort_wdata),
    .a_gt_b_o (a_gt_b),
    .last_i_o (last_i),
    .last_j_o (last_j)
  );

  sorter_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .a_gt_b_i    (a_gt_b),
    .last_i_i    (last_i),
    .last_j_i    (last_j),
    .ld_i_o      (ld_i),
    .inc_i_o     (inc_i),
    .ld_j_o      (ld_j),
    .inc_j_o     (inc_j),
    .en_a_o      (en_a),
    .en_b_o      (en_b),
    .sel_j_o     (sel_j),
    .wsel_b_o    (wsel_b),
    .sort_we_o   (sort_we),
    .host_mode_o (host_mode),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else         rd_valid_q <= rd_i && host_ok;
  end

  assign out_valid_o = rd_valid_q;
  assign rdata_o     = rd_valid_q ? mem_rdata : '0;

  assert_no_read_in_sort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(!start_i));

endmodule

// File: tb/exch_sorter_bench.sv
module exch_sorter_bench;
  localparam int W  = 4;
  localparam int D  = 5;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic          ov, done;
  logic [W-1:0]  rdata;

  exch_sorter #(.WIDTH(W), .DEPTH(D)) u_exch_sorter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rd_i(rd), .out_valid_o(ov), .rdata_o(rdata), .done_o(done)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    n_chk = 0, n_fail = 0;
  bit    finished = 1'b0;
  int    exp_q[$];
  string tag_q[$];
  int    model[D];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a word is presented
  always @(negedge clk) begin
    if (rst_n && ov) begin
      if (exp_q.size() == 0) check(1'b0, "R8 valid with no pending read", 1, 0);
      else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(rdata) == e, t, int'(rdata), e);
      end
    end
  end

  task automatic write_word(input int a, input int d);
    @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = W'(d);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic read_push(input int a, input int e, input string t);
    @(negedge clk); rd = 1'b1; addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic load(input int v[D]);
    for (int a = 0; a < D; a++) begin
      model[a] = v[a];
      write_word(a, v[a]);
    end
  endtask

  task automatic model_sort();
    for (int p = 0; p < D; p++)
      for (int q = 0; q < D - 1; q++)
        if (model[q] > model[q+1]) begin
          int t;
          t = model[q]; model[q] = model[q+1]; model[q+1] = t;
        end
  endtask

  task automatic run_sort(input string name, input bit poke);
    int cyc;
    model_sort();
    @(negedge clk); start = 1'b1;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        wr = 1'b1; addr = '0; wdata = '0; rd = 1'b1;  // R6 and R8 stimulus mid-sort
      end else begin
        wr = 1'b0; rd = 1'b0;
      end
    end
    wr = 1'b0; rd = 1'b0;
    check(done && cyc <= 7*D*D, $sformatf("R9 %s sort cycles", name), cyc, 7*D*D);
    // done phase: try to overwrite the top slot, and read (R6, R8)
    wr = 1'b1; addr = AW'(D-1); wdata = '0; rd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      check(done, $sformatf("R5 %s done held", name), int'(done), 1);
    end
    start = 1'b0;
    @(negedge clk);
    check(!done, $sformatf("R5 %s done released", name), int'(done), 0);
    for (int a = 0; a < D; a++)
      read_push(a, model[a], $sformatf("R4 R7 R6 %s word %0d", name, a));
  endtask

  initial begin
    int p1[D] = '{9, 3, 12, 3, 1};
    int p2[D] = '{15, 12, 9, 4, 1};
    int p3[D] = '{0, 2, 2, 5, 15};
    int p4[D] = '{7, 7, 7, 7, 7};
    int p5[D] = '{15, 0, 15, 0, 8};
    repeat (3) @(negedge clk);
    check(!done, "R1 done after reset", int'(done), 0);
    check(!ov, "R1 valid after reset", int'(ov), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata == '0 && !ov, "R3 idle output zero", int'(rdata), 0);

    load(p1);
    for (int a = 0; a < D; a++) read_push(a, p1[a], $sformatf("R2 R3 load word %0d", a));
    run_sort("shuffled", 1'b1);
    load(p2); run_sort("reversed", 1'b1);
    load(p3); run_sort("presorted", 1'b0);
    load(p4); run_sort("equal", 1'b1);

    // reset in the middle of a sort
    load(p2);
    @(negedge clk); start = 1'b1;
    repeat (6) @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    @(negedge clk);
    check(!done && !ov, "R1 mid-sort reset outputs", int'(done), 0);
    rst_n = 1'b1;
    load(p5); run_sort("extremes", 1'b0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule